// File: doc/BRIEF.md
# Converter Serial Configuration and Power Sequencer

This block is the digital front end of a two-input successive-approximation converter. A host drives a four-wire serial slave port: a chip select (active low), a serial clock, a data input and a data output. Each transfer is a 16-clock frame. During the frame the block returns the last conversion result on the data output. At the same time it takes an 8-bit configuration byte from the data input. It then decodes that byte into a reference enable, a single/dual input mode, a channel select and a two-bit power policy.

The analog converter is outside the block and is modelled as a handshake. After a complete frame the block pulses a conversion request with the selected channel. The converter answers with a done pulse and a result word, which the block holds for the next frame. The block also runs a power sequencer. Under the chosen policy it moves the core between shutdown, standby, a timed wake-up and full power. It flags any conversion requested before the core is fully awake. All serial inputs are oversampled in the system clock domain, and wake-up delays are counted in system clock cycles.

Top module: `adc_ctrl_seq`

## Requirements
- R1: After reset the configuration is all zeros, so `ref_en`=1, `dual_mode`=0, `conv_ch`=0 and `pwr_state`=0 (shutdown). Also `dout_oe`=0 and `proto_err`=0, `result_invalid`=0, and no request has been issued.
- R2: The bits sampled on the first eight rising serial-clock edges after chip select falls form the configuration byte, MSB first. The byte takes effect at the 16th rising edge. Bits on rising edges 9 to 16 are ignored.
- R3: If chip select rises before the 16th rising edge, the frame is aborted. The configuration stays unchanged and no conversion request is issued.
- R4: Configuration decode: bit 5 = 1 turns the reference off (`ref_en`=0). Bit 4 = 1 selects dual mode. Bit 3 picks the channel, and `conv_ch` equals bit 3 only in dual mode, otherwise 0. Bits 1:0 select the power policy. Bit 7 is don't-care.
- R5: The data output carries 4 zeros and then the 12-bit result, MSB first. It advances on each falling serial-clock edge, so bit k is valid at rising edge k+1. `dout_oe` is 1 only while chip select is low.
- R6: A complete frame produces exactly one single-cycle `conv_req`. A `conv_done` pulse latches `conv_result`, which is read out in the next frame.
- R7: Policy 0: a chip-select fall starts a wake-up from shutdown of `WAKE_SHUT` cycles, and a chip-select rise returns the core to shutdown. `pwr_state` encoding: 0 shutdown, 1 standby, 2 waking, 3 full power.
- R8: Policy 1: the core wakes and then stays at full power; chip-select edges and `conv_done` do not power it down.
- R9: Policy 2: `conv_done` puts the core into shutdown; the next chip-select fall starts a `WAKE_SHUT`-cycle wake-up. The core never goes from shutdown straight to full power.
- R10: Policy 3: `conv_done` puts the core into standby, and a chip-select fall wakes it in `WAKE_STBY` cycles.
- R11: At each request, `result_invalid` becomes 1 if the core was not at full power and 0 if it was. It holds until the next request.
- R12: `proto_err` becomes 1 when a committed byte has bit 6 or bit 2 set, and 0 otherwise. The byte is still applied. It changes only at a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from host |
| din | input | 1 | Serial configuration data in |
| dout | output | 1 | Serial result data out |
| dout_oe | output | 1 | Output enable for dout (high while selected) |
| conv_req | output | 1 | One-cycle conversion request |
| conv_ch | output | 1 | Channel for the requested conversion |
| conv_done | input | 1 | Converter finished, result valid |
| conv_result | input | RES_W | Converter result word |
| ref_en | output | 1 | Internal reference enable |
| dual_mode | output | 1 | Two-input mode selected |
| pwr_state | output | 2 | Core power state (0 shut, 1 standby, 2 waking, 3 full) |
| core_ready | output | 1 | Core at full power |
| result_invalid | output | 1 | Last request was issued before wake-up ended |
| proto_err | output | 1 | Last committed byte wrote a reserved bit |

## Verification
Several properties are checked on every clock cycle. The request is a single pulse, and a request made at full power never raises the invalid flag. The error flag moves only at a commit, and a frame starts with a leading zero. Under the always-on policy full power is held, the core never skips from shutdown to full power, and standby is entered only after a done pulse. Other behaviour can only be shown by the bench's scenarios. These are the frame contents read back bit by bit, the effect of aborted frames and of trailing bits on the configuration, and the wake-up lengths of each policy. The bench shows the wake-up lengths by varying the serial clock rate so that a frame finishes either before or after the core is awake.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

  typedef enum logic [1:0] {
    PWR_SHUT = 2'd0,
    PWR_STBY = 2'd1,
    PWR_WAKE = 2'd2,
    PWR_FULL = 2'd3
  } pwr_state_e;

  typedef enum logic [1:0] {
    PM_CS_GATED = 2'd0,
    PM_ALWAYS   = 2'd1,
    PM_AUTO_OFF = 2'd2,
    PM_AUTO_SBY = 2'd3
  } pm_mode_e;

  // bit positions of the configuration byte that the decoder depends on
  localparam int CFG_REF_OFF = 5;
  localparam int CFG_DUAL    = 4;
  localparam int CFG_CHAN    = 3;
  localparam int CFG_PM_HI   = 1;
  localparam int CFG_PM_LO   = 0;
  localparam logic [7:0] CFG_RESV_MASK = 8'b0100_0100;

endpackage

// File: rtl/adc_in_sync.sv
module adc_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk,
  input  logic din,
  output logic cs_s,
  output logic din_s,
  output logic cs_fall,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall
);

  logic [STAGES-1:0] cs_pipe, sck_pipe, din_pipe;
  logic cs_prev, sck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_pipe  <= '1;
      sck_pipe <= '0;
      din_pipe <= '0;
      cs_prev  <= 1'b1;
      sck_prev <= 1'b0;
    end else begin
      cs_pipe  <= {cs_pipe[STAGES-2:0], cs_n};
      sck_pipe <= {sck_pipe[STAGES-2:0], sclk};
      din_pipe <= {din_pipe[STAGES-2:0], din};
      cs_prev  <= cs_pipe[STAGES-1];
      sck_prev <= sck_pipe[STAGES-1];
    end
  end

  assign cs_s     = cs_pipe[STAGES-1];
  assign din_s    = din_pipe[STAGES-1];
  assign cs_fall  = cs_prev & ~cs_s;
  assign cs_rise  = ~cs_prev & cs_s;
  assign sck_rise = ~sck_prev & sck_pipe[STAGES-1];
  assign sck_fall = sck_prev & ~sck_pipe[STAGES-1];

endmodule

// File: rtl/adc_frame_engine.sv
module adc_frame_engine #(
  parameter int CTRL_W    = 8,
  parameter int RES_W     = 12,
  parameter int FRAME_LEN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              din_s,
  input  logic [RES_W-1:0]  result,
  output logic              dout,
  output logic              commit,
  output logic [CTRL_W-1:0] cfg_word
);

  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam int LEAD  = FRAME_LEN - RES_W;
  localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] CFG_EDGES = CNT_W'(CTRL_W);

  logic [CNT_W-1:0]     edge_cnt;
  logic                 active;
  logic [CTRL_W-1:0]    rx_sr;
  logic [FRAME_LEN-1:0] tx_sr;
  logic                 commit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_cnt <= '0;
      active   <= 1'b0;
      rx_sr    <= '0;
      tx_sr    <= '0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (cs_fall) begin
        active   <= 1'b1;
        edge_cnt <= '0;
        tx_sr    <= {{LEAD{1'b0}}, result};
      end else if (cs_rise) begin
        active <= 1'b0;
      end else if (!cs_s && active) begin
        if (sck_rise) begin
          if (edge_cnt < CFG_EDGES)
            rx_sr <= {rx_sr[CTRL_W-2:0], din_s};
          if (edge_cnt == LAST_EDGE) begin
            commit_q <= 1'b1;
            active   <= 1'b0;
          end
          edge_cnt <= edge_cnt + 1'b1;
        end
        if (sck_fall)
          tx_sr <= {tx_sr[FRAME_LEN-2:0], 1'b0};
      end
    end
  end

  assign dout     = tx_sr[FRAME_LEN-1];
  assign commit   = commit_q;
  assign cfg_word = rx_sr;

  // R5: every frame opens with a leading zero on the data output
  assert_lead_zero_R5: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> !dout);

  // R3: chip select rising mid-frame never yields a commit
  assert_abort_no_commit_R3: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && edge_cnt != LAST_EDGE) |=> !commit_q);

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_ctrl_pkg::*;
#(
  parameter int WAKE_SHUT = 1000,
  parameter int WAKE_STBY = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  pm_mode_e   mode,
  input  logic       cs_fall,
  input  logic       cs_rise,
  input  logic       conv_done,
  output pwr_state_e state,
  output logic       ready
);

  localparam int CW = $clog2(WAKE_SHUT + 1);

  pwr_state_e    state_q;
  logic [CW-1:0] wake_cnt;
  logic          awake, wake_evt, to_shut, to_stby;

  always_comb begin
    awake    = (state_q == PWR_FULL) || (state_q == PWR_WAKE);
    wake_evt = (mode == PM_ALWAYS) || cs_fall;
    to_shut  = awake && (((mode == PM_CS_GATED) && cs_rise) ||
                         ((mode == PM_AUTO_OFF) && conv_done));
    to_stby  = awake && (mode == PM_AUTO_SBY) && conv_done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= PWR_SHUT;
      wake_cnt <= '0;
    end else if (to_shut) begin
      state_q <= PWR_SHUT;
    end else if (to_stby) begin
      state_q <= PWR_STBY;
    end else begin
      case (state_q)
        PWR_SHUT: if (wake_evt) begin
          state_q  <= PWR_WAKE;
          wake_cnt <= CW'(WAKE_SHUT);
        end
        PWR_STBY: if (wake_evt) begin
          state_q  <= PWR_WAKE;
          wake_cnt <= CW'(WAKE_STBY);
        end
        PWR_WAKE: begin
          if (wake_cnt <= CW'(1)) state_q <= PWR_FULL;
          else wake_cnt <= wake_cnt - 1'b1;
        end
        default: state_q <= PWR_FULL;
      endcase
    end
  end

  assign state = state_q;
  assign ready = (state_q == PWR_FULL);

  // R8: the always-on policy holds full power
  assert_always_on_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_ALWAYS && state_q == PWR_FULL) |=> state_q == PWR_FULL);

  // R9: shutdown must pass through the wake-up state
  assert_no_skip_wake_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == PWR_SHUT) |=> state_q != PWR_FULL);

  // R10: standby is entered only after a conversion completes
  assert_stby_after_done_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == PWR_STBY && $past(state_q) != PWR_STBY) |-> $past(conv_done));

endmodule

// File: rtl/adc_ctrl_seq.sv
module adc_ctrl_seq
  import adc_ctrl_pkg::*;
#(
  parameter int CTRL_W      = 8,
  parameter int RES_W       = 12,
  parameter int FRAME_LEN   = 16,
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_SHUT   = 1000,
  parameter int WAKE_STBY   = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             din,
  output logic             dout,
  output logic             dout_oe,
  output logic             conv_req,
  output logic             conv_ch,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic             ref_en,
  output logic             dual_mode,
  output logic [1:0]       pwr_state,
  output logic             core_ready,
  output logic             result_invalid,
  output logic             proto_err
);

  logic cs_s, din_s, cs_fall, cs_rise, sck_rise, sck_fall;
  logic commit;
  logic [CTRL_W-1:0] cfg_word;
  logic [RES_W-1:0]  result_q;
  logic ref_off_q, dual_q, chan_q, req_q, invalid_q, perr_q, oe_q;
  pm_mode_e   mode_q;
  pwr_state_e pstate;
  logic       pready;

  adc_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
    .cs_s(cs_s), .din_s(din_s), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall)
  );

  adc_frame_engine #(.CTRL_W(CTRL_W), .RES_W(RES_W), .FRAME_LEN(FRAME_LEN)) u_frame (
    .clk(clk), .rst(rst), .cs_s(cs_s), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .din_s(din_s), .result(result_q),
    .dout(dout), .commit(commit), .cfg_word(cfg_word)
  );

  adc_pwr_seq #(.WAKE_SHUT(WAKE_SHUT), .WAKE_STBY(WAKE_STBY)) u_pwr (
    .clk(clk), .rst(rst), .mode(mode_q), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .conv_done(conv_done), .state(pstate), .ready(pready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_off_q <= 1'b0;
      dual_q    <= 1'b0;
      chan_q    <= 1'b0;
      mode_q    <= PM_CS_GATED;
      perr_q    <= 1'b0;
      req_q     <= 1'b0;
      invalid_q <= 1'b0;
      result_q  <= '0;
      oe_q      <= 1'b0;
    end else begin
      oe_q  <= ~cs_s;
      req_q <= commit;
      if (commit) begin
        ref_off_q <= cfg_word[CFG_REF_OFF];
        dual_q    <= cfg_word[CFG_DUAL];
        chan_q    <= cfg_word[CFG_CHAN];
        mode_q    <= pm_mode_e'(cfg_word[CFG_PM_HI:CFG_PM_LO]);
        perr_q    <= |(cfg_word & CFG_RESV_MASK);
      end
      if (req_q) invalid_q <= ~pready;
      if (conv_done) result_q <= conv_result;
    end
  end

  assign dout_oe        = oe_q;
  assign conv_req       = req_q;
  assign conv_ch        = dual_q & chan_q;
  assign ref_en         = ~ref_off_q;
  assign dual_mode      = dual_q;
  assign pwr_state      = pstate;
  assign core_ready     = pready;
  assign result_invalid = invalid_q;
  assign proto_err      = perr_q;

  // R6: a request lasts exactly one cycle
  assert_req_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    conv_req |=> !conv_req);

  // R11: a request made at full power reports a valid result
  assert_valid_at_full_R11: assert property (@(posedge clk) disable iff (rst)
    (conv_req && pstate == PWR_FULL) |=> !result_invalid);

  // R12: the error flag only moves at a commit
  assert_perr_only_commit_R12: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(proto_err));

endmodule

// File: tb/adc_ctrl_seq_tb.sv
module adc_ctrl_seq_tb;

  localparam int RES_W = 12;
  localparam int FAST  = 8;
  localparam int SLOW  = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic dout, dout_oe, conv_req, conv_ch, ref_en, dual_mode, core_ready;
  logic result_invalid, proto_err;
  logic [1:0] pwr_state;
  logic conv_done = 1'b0;
  logic [RES_W-1:0] conv_result = '0;

  int checks = 0;
  int errors = 0;
  int nreq = 0;
  logic [RES_W-1:0] last_res = '0;
  logic [RES_W-1:0] next_res = 12'h9C3;
  logic [15:0] exp_q[$];

  always #2.5 clk = ~clk;

  adc_ctrl_seq #(.WAKE_SHUT(300), .WAKE_STBY(10)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
    .dout(dout), .dout_oe(dout_oe), .conv_req(conv_req), .conv_ch(conv_ch),
    .conv_done(conv_done), .conv_result(conv_result), .ref_en(ref_en),
    .dual_mode(dual_mode), .pwr_state(pwr_state), .core_ready(core_ready),
    .result_invalid(result_invalid), .proto_err(proto_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // converter model and request counter
  always @(negedge clk) if (!rst && conv_req) nreq++;

  initial begin
    forever begin
      @(negedge clk);
      if (conv_req) begin
        repeat (4) @(negedge clk);
        conv_result = next_res;
        conv_done   = 1'b1;
        last_res    = next_res;
        @(negedge clk);
        conv_done = 1'b0;
        next_res  = next_res + 12'h137;
      end
    end
  end

  // scoreboard monitor: collects dout at each rising serial clock
  initial begin
    forever begin
      logic [15:0] w;
      int n;
      @(negedge cs_n);
      w = '0;
      n = 0;
      forever begin
        @(posedge sclk or posedge cs_n);
        if (cs_n) break;
        w = {w[14:0], dout};
        n++;
        if (n == 1) chk(dout_oe == 1'b1, "R5 oe", 32'(dout_oe), 32'd1);
        if (n == 16) begin
          if (exp_q.size() == 0) chk(1'b0, "R5 empty queue", 32'(w), 32'd0);
          else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            chk(w == e, "R5/R6 frame data", 32'(w), 32'(e));
          end
        end
      end
    end
  end

  // driver: one frame, trailing eight bits all ones (must be ignored, R2)
  task automatic frame(input logic [7:0] cfg, input int half, input int nrise);
    logic [15:0] tx;
    tx = {cfg, 8'hFF};
    if (nrise == 16) exp_q.push_back({4'b0000, last_res});
    @(negedge clk);
    cs_n = 1'b0;
    din  = tx[15];
    repeat (half) @(negedge clk);
    for (int i = 0; i < nrise; i++) begin
      sclk = 1'b1;
      repeat (half) @(negedge clk);
      sclk = 1'b0;
      din = (i < 15) ? tx[14-i] : 1'b0;
      repeat (half) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (150) @(negedge clk);
  endtask

  initial begin
    int r0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(ref_en == 1'b1, "R1 ref_en", 32'(ref_en), 32'd1);
    chk(dual_mode == 1'b0 && conv_ch == 1'b0, "R1 mode/ch", 32'({dual_mode, conv_ch}), 32'd0);
    chk(pwr_state == 2'd0, "R1 pwr_state", 32'(pwr_state), 32'd0);
    chk(dout_oe == 1'b0, "R1 dout_oe", 32'(dout_oe), 32'd0);
    chk(proto_err == 1'b0 && result_invalid == 1'b0, "R1 flags",
        32'({proto_err, result_invalid}), 32'd0);
    chk(nreq == 0, "R1 no request", 32'(nreq), 32'd0);

    // A: policy 0 at start, fast frame -> request before wake ends (R7, R11); sets policy 1
    frame(8'h01, FAST, 16);
    chk(nreq == 1, "R6 one request", 32'(nreq), 32'd1);
    chk(result_invalid == 1'b1, "R7/R11 early request invalid", 32'(result_invalid), 32'd1);
    chk(pwr_state == 2'd3, "R8 full after CS rise", 32'(pwr_state), 32'd3);

    // B: policy 1 held full -> valid; writes ref off, dual, ch1, policy 0 (R4, R2)
    frame(8'hB8, FAST, 16);
    chk(result_invalid == 1'b0, "R11 valid at full", 32'(result_invalid), 32'd0);
    chk(ref_en == 1'b0, "R4 ref off", 32'(ref_en), 32'd0);
    chk(dual_mode == 1'b1 && conv_ch == 1'b1, "R4 dual ch1", 32'({dual_mode, conv_ch}), 32'd3);
    chk(pwr_state == 2'd0, "R7 shutdown on CS rise", 32'(pwr_state), 32'd0);
    chk(proto_err == 1'b0, "R2 trailing ones ignored", 32'(proto_err), 32'd0);

    // abort after 10 edges (R3)
    r0 = nreq;
    frame(8'h01, FAST, 10);
    chk(nreq == r0, "R3 no request on abort", 32'(nreq), 32'(r0));
    chk(ref_en == 1'b0 && dual_mode == 1'b1, "R3 config kept", 32'({ref_en, dual_mode}), 32'd1);
    chk(pwr_state == 2'd0, "R7 back to shutdown", 32'(pwr_state), 32'd0);

    // C: slow frame under policy 0 -> wake completes (R7); sets policy 2, dual ch0
    frame(8'h12, SLOW, 16);
    chk(result_invalid == 1'b0, "R7 slow frame valid", 32'(result_invalid), 32'd0);
    chk(conv_ch == 1'b0 && ref_en == 1'b1, "R4 ch0 ref on", 32'({conv_ch, ref_en}), 32'd1);
    chk(pwr_state == 2'd0, "R9 shutdown after done", 32'(pwr_state), 32'd0);

    // D: policy 2 fast frame -> invalid
    frame(8'h12, FAST, 16);
    chk(result_invalid == 1'b1, "R9 fast frame invalid", 32'(result_invalid), 32'd1);
    chk(pwr_state == 2'd0, "R9 shutdown again", 32'(pwr_state), 32'd0);

    // E: slow frame, sets policy 3
    frame(8'h13, SLOW, 16);
    chk(result_invalid == 1'b0, "R9 slow frame valid", 32'(result_invalid), 32'd0);
    chk(pwr_state == 2'd1, "R10 standby after done", 32'(pwr_state), 32'd1);

    // F: standby wakes quickly, fast frame valid
    frame(8'h13, FAST, 16);
    chk(result_invalid == 1'b0, "R10 fast standby wake valid", 32'(result_invalid), 32'd0);
    chk(pwr_state == 2'd1, "R10 standby again", 32'(pwr_state), 32'd1);

    // G/H: reserved bits (R12)
    frame(8'h53, FAST, 16);
    chk(proto_err == 1'b1, "R12 bit6 error", 32'(proto_err), 32'd1);
    chk(pwr_state == 2'd1, "R12 byte still applied", 32'(pwr_state), 32'd1);
    frame(8'h17, FAST, 16);
    chk(proto_err == 1'b1, "R12 bit2 error", 32'(proto_err), 32'd1);
    frame(8'h11, FAST, 16);
    chk(proto_err == 1'b0, "R12 clears", 32'(proto_err), 32'd0);
    repeat (400) @(negedge clk);
    chk(pwr_state == 2'd3, "R8 always on", 32'(pwr_state), 32'd3);
    chk(dout_oe == 1'b0, "R5 oe idle", 32'(dout_oe), 32'd0);
    chk(exp_q.size() == 0, "R5 all frames seen", 32'(exp_q.size()), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule